// File: doc/BRIEF.md
# Group-Coded Serial Configuration Loader

This block is the host-facing configuration front end of a two-channel frequency synthesizer. A host drives three slow lines: a serial clock, a data line and an enable. The block samples them with a fast system clock. Each rising edge of the serial clock shifts one data bit into a shared shift register, with the first bit sent becoming the most significant. Words may be of different lengths. Raising the enable ends a word.

When the enable rises, the two bits shifted in last form a routing code. The code picks one of four holding registers: the control word, the channel-1 divide ratio, the channel-2 divide ratio or the reference divide ratio. The bits just above the code are copied into the chosen register, aligned so that the last payload bit lands in its least significant position.

The two lowest control bits select the charge-pump current. The block outputs this choice as a one-hot code. A readiness flag goes high once both the reference and the control registers have been written after reset. This lets the system see that the required power-up order has been followed before channel data is trusted.

Top module: `synth_serial_loader`

## Requirements
- R1: While reset is asserted and right after it, all four holding registers read zero, `cpSel` reads 4'b0001 and `cfgReady` is low.
- R2: One data bit is shifted in per rising edge of `serClk` while `serEn` is low, and the first bit sent ends up most significant. Falling edges of `serClk` shift nothing.
- R3: On a rising edge of `serEn`, the last bit shifted in is GC1 and the one before it is GC2. The pair (GC2,GC1) selects the target: 00 control, 10 channel 1, 01 channel 2, 11 reference.
- R4: A channel load copies the 17 bits just above the routing code into `ch1Div` or `ch2Div`. The last payload bit goes to bit 0.
- R5: A reference load copies the 12 bits just above the routing code into `refDiv`. The last payload bit goes to bit 0.
- R6: A control load copies the CTL_W (default 6) bits just above the routing code into `ctlWord`. Each load changes only the selected register.
- R7: `ctlWord[1]` is the first pump select bit and `ctlWord[0]` the second. `cpSel` is one-hot: (1st,2nd) = 00 gives bit 0 (100 µA), 10 gives bit 1 (200 µA), 01 gives bit 2 (400 µA), 11 gives bit 3 (800 µA).
- R8: While `serEn` is high, `serClk` edges shift nothing. No register changes again until `serEn` has gone low and then high again.
- R9: If a `serClk` rise and a `serEn` rise reach the block in the same system cycle, that clock edge is not shifted. The load then uses the register contents from before that edge.
- R10: `cfgReady` goes high once the reference register and the control register have each been written since reset, in either order. Channel loads do not affect it, and it stays high until reset.
- R11: A holding register takes its new value on the third rising `clk` edge, counting the first edge at which `serEn` is sampled high.
- R12: Bits sent before the payload and routing code of a word have no effect on the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Host serial clock, asynchronous |
| serData | input | 1 | Host serial data, asynchronous |
| serEn | input | 1 | Host load enable, asynchronous |
| ctlWord | output | CTL_W | Control holding register |
| ch1Div | output | N_W | Channel-1 divide ratio |
| ch2Div | output | N_W | Channel-2 divide ratio |
| refDiv | output | R_W | Reference divide ratio |
| cpSel | output | 4 | One-hot charge-pump current select |
| cfgReady | output | 1 | Reference and control both written since reset |

## Verification
A shift of a new bit and a load of the holding register can fall in the same system cycle. The bench provokes this by raising `serClk` and `serEn` at the same instant, so both edges leave the synchronizers together. The expected result is that the final bit is dropped. The routing code and payload are therefore taken one bit higher than the host intended. With the chosen pattern, this sends the word to the reference register instead of channel 1, and the bench checks both registers against a behavioural model that it compares on every clock.

// File: rtl/sload_pkg.sv
package sload_pkg;

  // Routing code as it sits in the two lowest shift-register bits {GC2, GC1}
  typedef enum logic [1:0] {
    GRP_CTL = 2'b00,
    GRP_CH2 = 2'b01,
    GRP_CH1 = 2'b10,
    GRP_REF = 2'b11
  } grp_e;

  // Strobes from control to datapath, valid for one system cycle
  typedef struct packed {
    logic shiftEn;
    logic bitIn;
    logic ldCtl;
    logic ldCh1;
    logic ldCh2;
    logic ldRef;
  } strobe_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sload_sync.sv
module sload_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sload_ctrl.sv
module sload_ctrl
  import sload_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serEn,
  input  grp_e    grpCode,
  output strobe_t strb,
  output logic    cfgReady
);

  localparam int NUM_IN = 3;
  localparam int IDX_CK = 0;
  localparam int IDX_DT = 1;
  localparam int IDX_EN = 2;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncd;
  logic clkPrev, enPrev;
  logic clkRise, enRise;
  logic seenRef, seenCtl;

  assign rawIn = {serEn, serData, serClk};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    sload_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rawIn[g]),
      .dout (syncd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev <= 1'b0;
      enPrev  <= 1'b0;
    end else begin
      clkPrev <= syncd[IDX_CK];
      enPrev  <= syncd[IDX_EN];
    end
  end

  assign clkRise = syncd[IDX_CK] & ~clkPrev;
  assign enRise  = syncd[IDX_EN] & ~enPrev;

  always_comb begin
    strb         = '0;
    strb.bitIn   = syncd[IDX_DT];
    // a clock edge seen while enable is high (including its rising cycle) is dropped
    strb.shiftEn = clkRise & ~syncd[IDX_EN];
    if (enRise) begin
      unique case (grpCode)
        GRP_CTL: strb.ldCtl = 1'b1;
        GRP_CH1: strb.ldCh1 = 1'b1;
        GRP_CH2: strb.ldCh2 = 1'b1;
        GRP_REF: strb.ldRef = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenRef <= 1'b0;
      seenCtl <= 1'b0;
    end else begin
      if (strb.ldRef) seenRef <= 1'b1;
      if (strb.ldCtl) seenCtl <= 1'b1;
    end
  end

  assign cfgReady = seenRef & seenCtl;

endmodule

// File: rtl/sload_dp.sv
module sload_dp
  import sload_pkg::*;
#(
  parameter int N_W   = 17,
  parameter int R_W   = 12,
  parameter int CTL_W = 6,
  parameter int SR_W  = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  output grp_e             grpCode,
  output logic [CTL_W-1:0] ctlWord,
  output logic [N_W-1:0]   ch1Div,
  output logic [N_W-1:0]   ch2Div,
  output logic [R_W-1:0]   refDiv,
  output logic [3:0]       cpSel
);

  localparam int GC_W = 2;

  logic [SR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sr <= '0;
    else if (strb.shiftEn) sr <= {sr[SR_W-2:0], strb.bitIn};
  end

  assign grpCode = grp_e'(sr[GC_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlWord <= '0;
      ch1Div  <= '0;
      ch2Div  <= '0;
      refDiv  <= '0;
    end else begin
      if (strb.ldCtl) ctlWord <= sr[CTL_W+GC_W-1:GC_W];
      if (strb.ldCh1) ch1Div  <= sr[N_W+GC_W-1:GC_W];
      if (strb.ldCh2) ch2Div  <= sr[N_W+GC_W-1:GC_W];
      if (strb.ldRef) refDiv  <= sr[R_W+GC_W-1:GC_W];
    end
  end

  // pump select: first select bit sits at ctlWord[1], second at ctlWord[0]
  always_comb begin
    cpSel = '0;
    cpSel[{ctlWord[0], ctlWord[1]}] = 1'b1;
  end

endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import sload_pkg::*;
#(
  parameter int N_W         = 17,
  parameter int R_W         = 12,
  parameter int CTL_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serEn,
  output logic [CTL_W-1:0] ctlWord,
  output logic [N_W-1:0]   ch1Div,
  output logic [N_W-1:0]   ch2Div,
  output logic [R_W-1:0]   refDiv,
  output logic [3:0]       cpSel,
  output logic             cfgReady
);

  localparam int SR_W = maxOf3(N_W, R_W, CTL_W) + 2;

  strobe_t strb;
  grp_e    grpCode;

  sload_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .serClk  (serClk),
    .serData (serData),
    .serEn   (serEn),
    .grpCode (grpCode),
    .strb    (strb),
    .cfgReady(cfgReady)
  );

  sload_dp #(.N_W(N_W), .R_W(R_W), .CTL_W(CTL_W), .SR_W(SR_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .grpCode(grpCode),
    .ctlWord(ctlWord),
    .ch1Div (ch1Div),
    .ch2Div (ch2Div),
    .refDiv (refDiv),
    .cpSel  (cpSel)
  );

endmodule

// File: rtl/sload_checker.sv
module sload_checker #(
  parameter int N_W   = 17,
  parameter int R_W   = 12,
  parameter int CTL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             serEn,
  input logic [CTL_W-1:0] ctlWord,
  input logic [N_W-1:0]   ch1Div,
  input logic [N_W-1:0]   ch2Div,
  input logic [R_W-1:0]   refDiv,
  input logic [3:0]       cpSel,
  input logic             cfgReady
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (ch1Div == '0 && ch2Div == '0 && refDiv == '0 &&
                               ctlWord == '0 && !cfgReady);
    end
  end

  // R6
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(ch1Div), !$stable(ch2Div), !$stable(refDiv), !$stable(ctlWord)}) <= 1);

  // R8
  load_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ch1Div) || !$stable(ch2Div) || !$stable(refDiv) || !$stable(ctlWord))
      |-> $past(serEn, 2));

  // R7
  pump_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cpSel) == 1);

  // R10
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cfgReady));

  // R10
  ready_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfgReady) |-> (!$stable(refDiv) || !$stable(ctlWord) || $past(serEn, 2)));

endmodule

bind synth_serial_loader sload_checker #(.N_W(N_W), .R_W(R_W), .CTL_W(CTL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .serEn   (serEn),
  .ctlWord (ctlWord),
  .ch1Div  (ch1Div),
  .ch2Div  (ch2Div),
  .refDiv  (refDiv),
  .cpSel   (cpSel),
  .cfgReady(cfgReady)
);

// File: tb/synth_serial_loader_bench.sv
module synth_serial_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_W   = 17;
  localparam int R_W   = 12;
  localparam int CTL_W = 6;
  localparam int T_SET = 4;   // data settle before clock rise
  localparam int T_HI  = 5;   // serial clock high
  localparam int T_LO  = 5;   // serial clock low
  localparam int T_GAP = 12;  // last clock edge to enable rise
  localparam int T_EN  = 6;   // enable high

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serEn = 1'b0;
  logic [CTL_W-1:0] ctlWord;
  logic [N_W-1:0]   ch1Div, ch2Div;
  logic [R_W-1:0]   refDiv;
  logic [3:0]       cpSel;
  logic             cfgReady;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_serial_loader u_synth_serial_loader (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .serEn(serEn),
    .ctlWord(ctlWord), .ch1Div(ch1Div), .ch2Div(ch2Div), .refDiv(refDiv),
    .cpSel(cpSel), .cfgReady(cfgReady)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] mSr;
  logic [N_W-1:0] mCh1, mCh2;
  logic [R_W-1:0] mRef;
  logic [CTL_W-1:0] mCtl;
  bit mSeenR, mSeenC;
  logic [2:0] h1, h2, h3; // {en, data, clk} seen 1, 2, 3 edges back

  always @(posedge clk) begin
    if (!rst_n) begin
      mSr = '0; mCh1 = '0; mCh2 = '0; mRef = '0; mCtl = '0;
      mSeenR = 0; mSeenC = 0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      if (h2[2] && !h3[2]) begin
        case ({mSr[1], mSr[0]})
          2'b00: begin mCtl = mSr[CTL_W+1:2]; mSeenC = 1; end
          2'b10: mCh1 = mSr[N_W+1:2];
          2'b01: mCh2 = mSr[N_W+1:2];
          default: begin mRef = mSr[R_W+1:2]; mSeenR = 1; end
        endcase
      end else if (h2[0] && !h3[0] && !h2[2]) begin
        mSr = {mSr[62:0], h2[1]};
      end
      h3 = h2; h2 = h1; h1 = {serEn, serData, serClk};
    end
  end

  function automatic logic [3:0] expPump(input logic [CTL_W-1:0] c);
    int ua;
    ua = 100 * (c[1] ? 2 : 1) * (c[0] ? 4 : 1);
    return (ua == 100) ? 4'b0001 : (ua == 200) ? 4'b0010 : (ua == 400) ? 4'b0100 : 4'b1000;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 ch1 model",   32'(ch1Div),   32'(mCh1));
      chk("R4 ch2 model",   32'(ch2Div),   32'(mCh2));
      chk("R5 ref model",   32'(refDiv),   32'(mRef));
      chk("R6 ctl model",   32'(ctlWord),  32'(mCtl));
      chk("R7 pump model",  32'(cpSel),    32'(expPump(mCtl)));
      chk("R10 ready model",32'(cfgReady), 32'(mSeenR && mSeenC));
    end
  end

  // ---------------- host stimulus ----------------
  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = w[i];
      waitN(T_SET);
      serClk = 1'b1;
      waitN(T_HI);
      serClk = 1'b0;
      waitN(T_LO);
    end
  endtask

  task automatic pulseEn();
    waitN(T_GAP);
    serEn = 1'b1;
    waitN(T_EN);
    serEn = 1'b0;
    waitN(T_LO);
  endtask

  task automatic sendWord(input logic [31:0] payload, input int plen, input logic [1:0] gc);
    sendBits({payload[29:0], gc}, plen + 2);
    pulseEn();
  endtask

  logic [N_W-1:0] p1, p2, pc;

  initial begin
    waitN(4);
    // R1: reset state
    chk("R1 ch1 reset", 32'(ch1Div), 0);
    chk("R1 ref reset", 32'(refDiv), 0);
    chk("R1 pump reset", 32'(cpSel), 32'h1);
    chk("R1 ready reset", 32'(cfgReady), 0);
    rst_n = 1'b1;
    waitN(3);
    chk("R1 ctl after reset", 32'(ctlWord), 0);

    // R2 R3 R4: channel 1 word, code (GC2,GC1)=10
    p1 = 17'h1ABCD;
    sendWord(32'(p1), N_W, 2'b10);
    chk("R2 R4 ch1 load", 32'(ch1Div), 32'(p1));
    chk("R3 ch2 untouched", 32'(ch2Div), 0);
    chk("R10 not ready after channel", 32'(cfgReady), 0);

    // R5: reference word, code 11
    sendWord(32'h0A5C, R_W, 2'b11);
    chk("R5 ref load", 32'(refDiv), 32'h0A5C);
    chk("R10 not ready without control", 32'(cfgReady), 0);

    // R6 R7: control word, pump bits (1st,2nd)=10 -> 200 uA
    sendWord(32'b101110, CTL_W, 2'b00);
    chk("R6 ctl load", 32'(ctlWord), 32'b101110);
    chk("R7 pump 200", 32'(cpSel), 32'b0010);
    chk("R10 ready", 32'(cfgReady), 1);
    sendWord(32'b000001, CTL_W, 2'b00);
    chk("R7 pump 400", 32'(cpSel), 32'b0100);
    sendWord(32'b110011, CTL_W, 2'b00);
    chk("R7 pump 800", 32'(cpSel), 32'b1000);
    sendWord(32'b010100, CTL_W, 2'b00);
    chk("R7 pump 100", 32'(cpSel), 32'b0001);

    // R12: channel 2 with three leading junk bits, code 01
    p2 = 17'h0F0F3;
    sendBits({3'b101, p2, 2'b01}, N_W + 5);
    pulseEn();
    chk("R12 R4 ch2 long word", 32'(ch2Div), 32'(p2));
    chk("R6 ch1 kept", 32'(ch1Div), 32'(p1));

    // R11: latency counted in system edges
    sendBits({17'h00777, 2'b10}, N_W + 2);
    waitN(T_GAP);
    serEn = 1'b1;      // first sampled at the next rising edge
    waitN(2);
    chk("R11 not yet after 2 edges", 32'(ch1Div), 32'(p1));
    waitN(1);
    chk("R11 loaded on 3rd edge", 32'(ch1Div), 32'h00777);
    p1 = 17'h00777;
    // R8: clock edges while enable high are dropped
    sendBits(32'hFFFF_FFFF, 5);
    chk("R8 no change while enable high", 32'(ch1Div), 32'(p1));
    serEn = 1'b0;
    waitN(T_LO);
    pulseEn();         // register unchanged, so channel 1 is reloaded with same data
    chk("R8 ch1 reload same", 32'(ch1Div), 32'(p1));
    chk("R8 ref untouched", 32'(refDiv), 32'h0A5C);

    // R9: clock rise and enable rise together; final bit 0 is dropped
    pc = 17'h12345;    // bit 0 is 1, so code becomes 11 (reference)
    sendBits({pc, 1'b1}, N_W + 1);
    serData = 1'b0;
    waitN(T_SET);
    serClk = 1'b1;
    serEn  = 1'b1;
    waitN(T_EN);
    serClk = 1'b0;
    serEn  = 1'b0;
    waitN(T_LO);
    chk("R9 collision ref", 32'(refDiv), 32'(pc[12:1]));
    chk("R9 collision ch1 kept", 32'(ch1Div), 32'(p1));
    chk("R10 ready stays", 32'(cfgReady), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule